// File: doc/BRIEF.md
# Timer DMA Request Router

The router sits between the twenty-four DMA request sources of a six-channel timer and four DMA request lines at the module boundary. Each timer channel raises four request levels: two capture read requests and two compare-load write requests. Each output line has its own enable bit and its own 5-bit source select. Software programs both through a small write port.

An enabled output with a valid select drives the chosen source's level, one clock later. A disabled output drives nothing. An output whose select holds a reserved code also drives nothing. Turning an output off removes only that output's request. The source level itself is left untouched, so other outputs routed to the same source keep requesting.

A status bit rises when two or more enabled outputs name the same valid source. This lets software catch a setup in which one source would trigger several transfers.

Top module: `dma_req_router`

## Requirements
- R1: After reset all outputs are disabled with select 0, `req_o` is all zero and `dup_o` is 0, even when every source is high.
- R2: Source code = channel*4 + kind, where kind 0 is capture-1 read, 1 is capture-2 read, 2 is compare-load-1 write and 3 is compare-load-2 write. Code c is bit c of `src_req_i`. An enabled output k with code c drives `req_o[k]` equal to `src_req_i[c]`, with one clock of latency.
- R3: A disabled output drives 0 on its `req_o` bit, whatever the source levels.
- R4: Codes 24 to 31 are reserved. An enabled output holding a reserved code drives 0.
- R5: Clearing one output's enable removes that output's request on the next registered cycle. Another enabled output selecting the same source keeps asserting.
- R6: A write to output k sets its enable to `cfg_en_i`. The write loads `cfg_sel_i` into the select only if output k was disabled before the write; the select of an enabled output is left unchanged.
- R7: `dup_o` is 1 one cycle after the configuration has two or more enabled outputs holding the same valid code. Matching codes on disabled outputs, or matching reserved codes, do not set it.
- R8: Several enabled outputs selecting the same valid source all assert together in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 2 | Output number targeted by the write |
| cfg_en_i | input | 1 | Enable value written |
| cfg_sel_i | input | 5 | Source code written (kept only if the output is disabled) |
| src_req_i | input | 24 | Source request levels, bit = channel*4 + kind |
| req_o | output | 4 | Registered module-level DMA requests |
| dup_o | output | 1 | Duplicate-routing status |

## Verification
If a select register is wrong, the affected `req_o` bit follows the wrong source one clock after that source toggles. The bench drives isolated and neighbouring source bits, so this shows up as a missing or spurious request. If an enable register is stuck, the bit fails to drop within one cycle of a disabling write. If the select lock is broken, an enabled output moves to the newly written code at the next registered cycle. If the duplicate comparator is wrong, the status bit mismatches on the cycle after the configuration write.

// File: rtl/dma_req_router_pkg.sv
package dma_req_router_pkg;
  localparam int unsigned NUM_CH     = 6;
  localparam int unsigned SRC_PER_CH = 4;
  localparam int unsigned NUM_SRC    = NUM_CH * SRC_PER_CH;
  localparam int unsigned SEL_W      = $clog2(NUM_SRC);
  localparam int unsigned NUM_OUT    = 4;
  localparam int unsigned OUT_W      = $clog2(NUM_OUT);

  typedef logic [SEL_W-1:0] sel_t;

  function automatic logic sel_valid(sel_t s);
    return int'(s) < NUM_SRC;
  endfunction
endpackage

// File: rtl/dma_route_cfg.sv
module dma_route_cfg
  import dma_req_router_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [OUT_W-1:0]        idx_i,
  input  logic                    en_i,
  input  sel_t                    sel_i,
  output logic [NUM_OUT-1:0]      en_o,
  output sel_t [NUM_OUT-1:0]      sel_o
);
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_reg
    logic hit;
    assign hit = we_i && (idx_i == OUT_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[k]  <= 1'b0;
        sel_o[k] <= '0;
      end else if (hit) begin
        en_o[k] <= en_i;
        // select locked while routed
        if (!en_o[k]) sel_o[k] <= sel_i;
      end
    end

    AST_SEL_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && en_o[k]) |=> $stable(sel_o[k])); // R6
  end
endmodule

// File: rtl/dma_route_mux.sv
module dma_route_mux
  import dma_req_router_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  sel_t               sel_i,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               req_o
);
  logic pick;

  always_comb begin
    pick = 1'b0;
    if (en_i && sel_valid(sel_i)) pick = src_i[sel_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= pick;
  end

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !req_o); // R3
  AST_RSVD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !sel_valid(sel_i)) |=> !req_o); // R4
endmodule

// File: rtl/dma_route_dup.sv
module dma_route_dup
  import dma_req_router_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_OUT-1:0]   en_i,
  input  sel_t [NUM_OUT-1:0]   sel_i,
  output logic                 dup_o
);
  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int a = 0; a < NUM_OUT; a++)
      for (int b = a + 1; b < NUM_OUT; b++)
        if (en_i[a] && en_i[b] && sel_valid(sel_i[a]) && sel_i[a] == sel_i[b])
          hit = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dup_o <= 1'b0;
    else         dup_o <= hit;
  end

  AST_DUP_NEEDS_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(en_i) < 2) |=> !dup_o); // R7
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dma_req_router_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [OUT_W-1:0]   cfg_idx_i,
  input  logic               cfg_en_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic [NUM_SRC-1:0] src_req_i,
  output logic [NUM_OUT-1:0] req_o,
  output logic               dup_o
);
  logic [NUM_OUT-1:0] en_q;
  sel_t [NUM_OUT-1:0] sel_q;

  dma_route_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .en_i   (cfg_en_i),
    .sel_i  (cfg_sel_i),
    .en_o   (en_q),
    .sel_o  (sel_q)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    dma_route_mux u_mux (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_q[k]),
      .sel_i  (sel_q[k]),
      .src_i  (src_req_i),
      .req_o  (req_o[k])
    );
  end

  dma_route_dup u_dup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .sel_i  (sel_q),
    .dup_o  (dup_o)
  );

  AST_SHARED_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q[0] && en_q[1] && sel_q[0] == sel_q[1]) |=> (req_o[0] == req_o[1])); // R8
  AST_DUP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q[2] && en_q[3] && sel_valid(sel_q[2]) && sel_q[2] == sel_q[3]) |=> dup_o); // R7
endmodule

// File: tb/tb_dma_req_router.sv
module tb_dma_req_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_idx_i = '0;
  logic        cfg_en_i = 1'b0;
  logic [4:0]  cfg_sel_i = '0;
  logic [23:0] src_req_i = '0;
  logic [3:0]  req_o;
  logic        dup_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dma_req_router dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i),
    .cfg_en_i(cfg_en_i), .cfg_sel_i(cfg_sel_i), .src_req_i(src_req_i),
    .req_o(req_o), .dup_o(dup_o)
  );

  // {source levels, expected req} with out0=0, out1=23, out2=10, out3=13
  localparam logic [27:0] VEC [8] = '{
    {24'h000001, 4'b0001},
    {24'h800000, 4'b0010},
    {24'h000400, 4'b0100},
    {24'h002000, 4'b1000},
    {24'hFFFFFF, 4'b1111},
    {24'h000000, 4'b0000},
    {24'h401802, 4'b0000},
    {24'h002001, 4'b1001}
  };

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, bit en, int sel);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = 2'(idx); cfg_en_i = en; cfg_sel_i = 5'(sel);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // apply sources, sample after one registered edge
  task automatic drive(logic [23:0] s);
    src_req_i = s;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 req after reset", req_o, 4'b0000);
    check("R1 dup after reset", {3'b0, dup_o}, 4'b0000);
    rst_ni = 1'b1;
    drive(24'hFFFFFF);
    check("R1 disabled outputs with sources high", req_o, 4'b0000);
    check("R3 all disabled", req_o, 4'b0000);

    wr(0, 1, 0); wr(1, 1, 23); wr(2, 1, 10); wr(3, 1, 13);
    for (int i = 0; i < 8; i++) begin
      drive(VEC[i][27:4]);
      check($sformatf("R2 vector %0d", i), req_o, VEC[i][3:0]);
    end
    check("R7 distinct codes", {3'b0, dup_o}, 4'b0000);

    // R3: disabling out2 while its source is high
    src_req_i = 24'hFFFFFF;
    wr(2, 0, 10);
    drive(24'hFFFFFF);
    check("R3 out2 disabled", req_o, 4'b1011);

    // R4: reserved codes on an enabled output
    wr(2, 1, 24);
    drive(24'hFFFFFF);
    check("R4 code 24", req_o, 4'b1011);
    wr(2, 0, 0); wr(2, 1, 31);
    drive(24'hFFFFFF);
    check("R4 code 31", req_o, 4'b1011);

    // R6: select write ignored while enabled
    wr(1, 1, 4);
    drive(24'h000010);
    check("R6 locked select ignores code 4", req_o & 4'b0010, 4'b0000);
    drive(24'h800000);
    check("R6 locked select keeps code 23", req_o & 4'b0010, 4'b0010);
    wr(1, 0, 4);
    drive(24'h800000);
    check("R6 enable still writable", req_o & 4'b0010, 4'b0000);
    wr(1, 1, 4);
    drive(24'h000010);
    check("R6 select loaded when disabled", req_o & 4'b0010, 4'b0010);

    // R7: reserved duplicates do not flag
    wr(3, 0, 0); wr(3, 1, 31);
    drive(24'h0);
    check("R7 reserved duplicate", {3'b0, dup_o}, 4'b0000);

    // R8 / R5: out0 and out1 both on code 5 (channel 1, capture 2)
    wr(0, 0, 0); wr(0, 1, 5); wr(1, 0, 0); wr(1, 1, 5);
    drive(24'h000020);
    check("R8 shared source", req_o & 4'b0011, 4'b0011);
    check("R7 duplicate flagged", {3'b0, dup_o}, 4'b0001);
    wr(0, 0, 5);
    drive(24'h000020);
    check("R5 disabled output drops, peer keeps", req_o & 4'b0011, 4'b0010);
    check("R7 disabled duplicate not flagged", {3'b0, dup_o}, 4'b0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule